// File: doc/BRIEF.md
# Code Density Delay Analyzer

This block measures the delay between a fixed reference clock and one of several later copies of it, entirely with digital logic. Each clock drives a toggle flop, so the exclusive OR of the two toggles is high for a stretch equal to the delay once per reference period. A free-running oscillator, unrelated in frequency to the reference, samples that window. One counter counts oscillator edges and a second counts the edges that found the window high. Because the oscillator edges fall uniformly over the reference period, the ratio of hits to edges estimates the delay as a fraction of that period. The estimate's spread shrinks with the inverse square root of the number of edges.

Measurement length, delayed-clock choice and a whole-cycle offset are set before a run. The offset passes the reference toggle through a shift chain of reference cycles before it reaches the delayed-clock flop, so a delay of several periods plus a fraction can be measured. Both counters stop together after a power-of-two number of edges and then hold their values. A flag in the readout clock domain tells the reader that the counts are final. The oscillator itself is outside the block. The block only holds the 5-bit trim code that the oscillator uses to keep its period longer than twice the largest delay.

Top module: `cdt_delay_analyzer`

## Requirements
- R1: While `rst` is high, `edge_cnt` and `hit_cnt` read zero and `done` reads 0.
- R2: After reset is released, the edge counter stops at exactly 2^(8+`frz_sel`) oscillator edges, where `frz_sel` is a 4-bit code.
- R3: The hit counter increments on each counted oscillator edge at which the window (reference toggle XOR delayed toggle) is high, so `hit_cnt` never exceeds `edge_cnt`. For an even cycle offset, `hit_cnt`/`edge_cnt` approximates ΔT/T.
- R4: Once the edge counter has stopped, both counts hold unchanged until the next reset.
- R5: `done` rises within three `rd_clk` edges of the freeze, and never before the edge count reaches its limit.
- R6: `clk_sel` (binary index) chooses which of the N delayed clocks is compared against the reference.
- R7: `cyc_del` = n delays the reference toggle by n reference cycles before the delayed flop. For odd n, the hit fraction approximates 1 − Δt/T, and for even n it approximates Δt/T.
- R8: `clk_sel`, `cyc_del`, `frz_sel` and `fine_code` are captured on `rd_clk` edges while `rst` is high. Changes made after reset is released have no effect on the run in progress.
- R9: `osc_trim` presents the 5-bit `fine_code` captured during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held across edges of every clock |
| ref_clk | input | 1 | Fixed reference clock |
| dly_clk | input | 4 | Delayed copies of the reference clock |
| osc_clk | input | 1 | Free-running asynchronous sampling oscillator |
| rd_clk | input | 1 | Readout clock |
| clk_sel | input | 2 | Index of the delayed clock to compare |
| cyc_del | input | 3 | Whole reference cycles of offset |
| frz_sel | input | 4 | Measurement length code, 2^(8+code) edges |
| fine_code | input | 5 | Oscillator trim request |
| osc_trim | output | 5 | Captured trim code for the oscillator |
| edge_cnt | output | 24 | Oscillator edges counted |
| hit_cnt | output | 24 | Edges that found the window high |
| done | output | 1 | Counts are final (readout domain) |

## Verification
The configuration and trim code are registered on a `rd_clk` edge during reset, so they are valid one readout cycle into reset. The counts reach their final values on the oscillator edge that counts the last sample. `done` follows two readout edges after that. The bench drives and samples on the falling edge of the 125 MHz clock that serves as both the reference and readout clock. It checks the counts only after `done` has been seen. It checks hold behaviour fifty cycles later. Hit counts are compared against ΔT/T or 1 − ΔT/T of the edge limit. The tolerance covers the start-up cycles before the offset chain fills.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    parameter int N_DLY    = 4;
    parameter int MAX_CYC  = 7;
    parameter int CNT_W    = 24;
    parameter int FRZ_W    = 4;
    parameter int TRIM_W   = 5;
    parameter int FRZ_BASE = 8;

    localparam int SEL_W = (N_DLY > 1) ? $clog2(N_DLY) : 1;
    localparam int CYC_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [CYC_W-1:0]  cyc;
        logic [FRZ_W-1:0]  frz;
        logic [TRIM_W-1:0] trim;
    } meas_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] edges;
        logic [CNT_W-1:0] hits;
        logic             frozen;
    } meas_cnt_t;

    function automatic logic [CNT_W-1:0] edge_limit(input logic [FRZ_W-1:0] f);
        return CNT_W'(1) << (FRZ_BASE + int'(f));
    endfunction

endpackage

// File: rtl/cdt_cfg_latch.sv
module cdt_cfg_latch
    import cdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  meas_cfg_t cfg_in,
    output meas_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/cdt_phase_gen.sv
module cdt_phase_gen
    import cdt_pkg::*;
(
    input  logic             rst,
    input  logic             ref_clk,
    input  logic [N_DLY-1:0] dly_clk,
    input  logic [SEL_W-1:0] sel,
    input  logic [CYC_W-1:0] cyc,
    output logic             window
);

    logic [MAX_CYC:0] tgl_chain;
    logic             tap;
    logic             sel_clk;
    logic             dly_tgl;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            tgl_chain[0] <= 1'b0;
        end else begin
            tgl_chain[0] <= ~tgl_chain[0];
        end
    end

    for (genvar k = 1; k <= MAX_CYC; k++) begin : g_chain
        always_ff @(posedge ref_clk) begin
            if (rst) begin
                tgl_chain[k] <= 1'b0;
            end else begin
                tgl_chain[k] <= tgl_chain[k-1];
            end
        end
    end

    assign tap     = tgl_chain[cyc];
    assign sel_clk = dly_clk[sel];

    always_ff @(posedge sel_clk) begin
        if (rst) begin
            dly_tgl <= 1'b0;
        end else begin
            dly_tgl <= tap;
        end
    end

    assign window = tgl_chain[0] ^ dly_tgl;

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
(
    input  logic             osc_clk,
    input  logic             rst,
    input  logic             window,
    input  logic [CNT_W-1:0] limit,
    output meas_cnt_t        cnt
);

    logic [CNT_W-1:0] edges_nxt;

    assign edges_nxt = cnt.edges + CNT_W'(1);

    always_ff @(posedge osc_clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!cnt.frozen) begin
            cnt.edges <= edges_nxt;
            cnt.hits  <= cnt.hits + CNT_W'(window);
            if (edges_nxt == limit) begin
                cnt.frozen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdt_done_sync.sv
module cdt_done_sync (
    input  logic clk,
    input  logic rst,
    input  logic flag_in,
    output logic flag_out
);

    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= 2'b00;
        end else begin
            stage <= {stage[0], flag_in};
        end
    end

    assign flag_out = stage[1];

endmodule

// File: rtl/cdt_delay_analyzer.sv
module cdt_delay_analyzer
    import cdt_pkg::*;
(
    input  logic                     rst,
    input  logic                     ref_clk,
    input  logic [N_DLY-1:0]         dly_clk,
    input  logic                     osc_clk,
    input  logic                     rd_clk,
    input  logic [SEL_W-1:0]         clk_sel,
    input  logic [CYC_W-1:0]         cyc_del,
    input  logic [FRZ_W-1:0]         frz_sel,
    input  logic [TRIM_W-1:0]        fine_code,
    output logic [TRIM_W-1:0]        osc_trim,
    output logic [CNT_W-1:0]         edge_cnt,
    output logic [CNT_W-1:0]         hit_cnt,
    output logic                     done
);

    meas_cfg_t        cfg_in;
    meas_cfg_t        cfg_q;
    meas_cnt_t        cnt;
    logic             window;
    logic [CNT_W-1:0] limit;

    assign cfg_in = '{sel: clk_sel, cyc: cyc_del, frz: frz_sel, trim: fine_code};

    cdt_cfg_latch u_cfg (
        .clk    (rd_clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    cdt_phase_gen u_phase (
        .rst     (rst),
        .ref_clk (ref_clk),
        .dly_clk (dly_clk),
        .sel     (cfg_q.sel),
        .cyc     (cfg_q.cyc),
        .window  (window)
    );

    assign limit = edge_limit(cfg_q.frz);

    cdt_counter u_cnt (
        .osc_clk (osc_clk),
        .rst     (rst),
        .window  (window),
        .limit   (limit),
        .cnt     (cnt)
    );

    cdt_done_sync u_done (
        .clk      (rd_clk),
        .rst      (rst),
        .flag_in  (cnt.frozen),
        .flag_out (done)
    );

    assign osc_trim = cfg_q.trim;
    assign edge_cnt = cnt.edges;
    assign hit_cnt  = cnt.hits;

endmodule

// File: rtl/cdt_delay_analyzer_chk.sv
module cdt_delay_analyzer_chk
    import cdt_pkg::*;
(
    input  logic             rst,
    input  logic             osc_clk,
    input  logic             rd_clk,
    input  logic [CNT_W-1:0] edge_cnt,
    input  logic [CNT_W-1:0] hit_cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic             frozen,
    input  logic             done,
    input  meas_cfg_t        cfg_q
);

    assert_edge_bound_R2: assert property (@(posedge osc_clk) disable iff (rst)
        edge_cnt <= limit);

    assert_hit_le_edge_R3: assert property (@(posedge osc_clk) disable iff (rst)
        hit_cnt <= edge_cnt);

    assert_edge_step_R2: assert property (@(posedge osc_clk) disable iff (rst)
        !frozen |=> (edge_cnt == $past(edge_cnt) + CNT_W'(1)) || rst);

    assert_hold_R4: assert property (@(posedge osc_clk) disable iff (rst)
        frozen |=> ($stable(edge_cnt) && $stable(hit_cnt)) || rst);

    assert_done_after_freeze_R5: assert property (@(posedge rd_clk) disable iff (rst)
        $rose(done) |-> frozen);

    assert_cfg_stable_R8: assert property (@(posedge rd_clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q));

endmodule

bind cdt_delay_analyzer cdt_delay_analyzer_chk u_chk (
    .rst      (rst),
    .osc_clk  (osc_clk),
    .rd_clk   (rd_clk),
    .edge_cnt (edge_cnt),
    .hit_cnt  (hit_cnt),
    .limit    (limit),
    .frozen   (cnt.frozen),
    .done     (done),
    .cfg_q    (cfg_q)
);

// File: tb/test_cdt_delay_analyzer.sv
`timescale 1ps/1ps
module test_cdt_delay_analyzer;
    import cdt_pkg::*;

    localparam int T_PS = 8000;
    localparam int OSC_HALF = 3465;
    localparam int DLY_PS [N_DLY] = '{1000, 2500, 3200, 500};

    logic             clk = 1'b0;
    logic             osc = 1'b0;
    logic             rst = 1'b1;
    logic [N_DLY-1:0] dly;
    logic [SEL_W-1:0] clk_sel = '0;
    logic [CYC_W-1:0] cyc_del = '0;
    logic [FRZ_W-1:0] frz_sel = '0;
    logic [TRIM_W-1:0] fine_code = '0;
    logic [TRIM_W-1:0] osc_trim;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] hit_cnt;
    logic             done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(T_PS/2) clk = ~clk;
    always #(OSC_HALF) osc = ~osc;

    for (genvar i = 0; i < N_DLY; i++) begin : g_dly
        assign #(DLY_PS[i]) dly[i] = clk;
    end

    cdt_delay_analyzer i_cdt_delay_analyzer (
        .rst       (rst),
        .ref_clk   (clk),
        .dly_clk   (dly),
        .osc_clk   (osc),
        .rd_clk    (clk),
        .clk_sel   (clk_sel),
        .cyc_del   (cyc_del),
        .frz_sel   (frz_sel),
        .fine_code (fine_code),
        .osc_trim  (osc_trim),
        .edge_cnt  (edge_cnt),
        .hit_cnt   (hit_cnt),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_hits(input int sel, input int cyc, input int m);
        real frac;
        frac = real'(DLY_PS[sel]) / real'(T_PS);
        if (cyc % 2 == 1) frac = 1.0 - frac;
        return longint'(frac * real'(longint'(1) << m) + 0.5);
    endfunction

    task automatic run(input int sel, input int cyc, input int frz, input int fine,
                       input bit disturb);
        int m;
        longint lim, eh, tol, e0, h0;
        int waited;
        m = FRZ_BASE + frz;
        lim = longint'(1) << m;
        @(negedge clk);
        rst = 1'b1;
        clk_sel = SEL_W'(sel);
        cyc_del = CYC_W'(cyc);
        frz_sel = FRZ_W'(frz);
        fine_code = TRIM_W'(fine);
        repeat (4) @(negedge clk);
        check(edge_cnt == 0, "R1 edge", edge_cnt, 0);
        check(hit_cnt == 0, "R1 hit", hit_cnt, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(osc_trim == TRIM_W'(fine), "R9 trim", osc_trim, fine);
        rst = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            clk_sel = SEL_W'(sel + 1);
            cyc_del = CYC_W'(cyc + 1);
            frz_sel = FRZ_W'(frz + 3);
            fine_code = ~TRIM_W'(fine);
        end
        waited = 0;
        while (!done && waited < 60000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R5 done seen", done, 1);
        check(longint'(edge_cnt) == lim, "R5 R2 edge at done", edge_cnt, lim);
        eh = exp_hits(sel, cyc, m);
        tol = lim / 64 + 8;
        check((longint'(hit_cnt) >= eh - tol) && (longint'(hit_cnt) <= eh + tol),
              (cyc % 2 == 1) ? "R7 R6 R3 hits odd offset" : "R6 R3 hits", hit_cnt, eh);
        if (disturb) check(osc_trim == TRIM_W'(fine), "R8 trim held", osc_trim, fine);
        e0 = edge_cnt;
        h0 = hit_cnt;
        repeat (50) @(negedge clk);
        check(longint'(edge_cnt) == e0, "R4 edge hold", edge_cnt, e0);
        check(longint'(hit_cnt) == h0, "R4 hit hold", hit_cnt, h0);
        check(done == 1'b1, "R5 done hold", done, 1);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        run(0, 0, 0, 5, 0);
        run(1, 0, 1, 17, 0);
        run(2, 1, 0, 31, 0);
        run(3, 2, 0, 0, 0);
        run(1, 3, 1, 9, 0);
        run(2, 0, 0, 12, 1);
        run(0, 7, 0, 3, 0);
        begin
            process p;
            p = process::self();
            p.srandom(32'd2024);
        end
        for (int r = 0; r < 8; r++) begin
            run(int'($urandom_range(N_DLY-1, 0)), int'($urandom_range(MAX_CYC, 0)),
                int'($urandom_range(2, 0)), int'($urandom_range(31, 0)),
                bit'($urandom_range(1, 0)));
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule